// File: doc/BRIEF.md
# Asynchronous memory cycle sequencer

This block runs single read or write cycles against an external asynchronous memory such as an SRAM or a flash part, all from one clock. A client raises a request with the operation, the address, the byte enables and the write data. The block then drives chip select, byte enables, address, output enable, a read strobe, a write strobe and the data bus through three timed phases: setup, strobe and hold. Each phase length is given in clock cycles by configuration inputs. Reads and writes have separate sets of values.

An asynchronous ready input from the memory can lengthen the strobe. Ready passes through a synchronizer first. It is examined only in the last two cycles of the programmed strobe. If it is seen low there, the strobe is frozen until ready is seen high again, and the strobe then ends after a fixed two-cycle release. On a read, the data is captured on the edge at which the strobe rises. A one-cycle done pulse marks the end of each cycle. A new request is accepted only while the block is idle.

Top module: `async_mem_seq`

## Requirements
- R1: After reset the block is idle: mem_cs_n, mem_oe_n, mem_re_n and mem_we_n are 1, mem_be_n is all ones, mem_dq_oe is 0, done is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle, mem_cs_n is 0 and the address and byte enables are driven. The strobe stays high for exactly the setup length in cycles.
- R3: A read uses cfg_rd_setup, cfg_rd_strobe and cfg_rd_hold. A write uses cfg_wr_setup, cfg_wr_strobe and cfg_wr_hold. While ready stays high, the strobe is low for exactly the strobe length in cycles. After the strobe rises, the selects stay driven for exactly the hold length in cycles.
- R4: A configured length of 0 behaves as a length of 1.
- R5: On a read, mem_oe_n and mem_re_n are low together during the strobe phase only. mem_we_n stays 1 and mem_dq_oe stays 0. rd_data takes mem_dq_i as sampled on the edge that ends the last strobe cycle.
- R6: On a write, mem_dq_oe is 1 and mem_dq_o equals the request's write data in every setup, strobe and hold cycle. mem_we_n is low only in the strobe phase. mem_oe_n and mem_re_n stay 1.
- R7: mem_ready passes through SYNC_STAGES flops before use. The synchronized ready is examined only from strobe cycle max(T-2,0), where T is the effective strobe length and cycles are counted from 0. A low ready seen before that cycle has no effect on the strobe length.
- R8: If the synchronized ready is low in a strobe cycle at or after the window start, the strobe is held one cycle at a time. When it is next seen high in cycle k, the strobe stays low through cycle k+1 and rises after that. With the default two stages, a ready that rises between the edges of strobe cycle m is first seen in cycle m+2, so the strobe lasts m+4 cycles.
- R9: done is 1 for exactly one cycle, the cycle after the last hold cycle. In that cycle mem_cs_n is already 1 and req_ready is 1.
- R10: req_ready is 0 from acceptance until done. A req_valid raised in that time starts no cycle and changes no driven pin.
- R11: The operation, address, byte enables, write data and the three selected lengths are captured at acceptance. Changes to these inputs later in the cycle have no effect.
- R12: Byte enables are active low: mem_be_n equals the bitwise inverse of req_be for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_be | input | DATA_W/8 | Request byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle end-of-cycle pulse |
| cfg_rd_setup | input | CNT_W | Read setup length |
| cfg_rd_strobe | input | CNT_W | Read strobe length |
| cfg_rd_hold | input | CNT_W | Read hold length |
| cfg_wr_setup | input | CNT_W | Write setup length |
| cfg_wr_strobe | input | CNT_W | Write strobe length |
| cfg_wr_hold | input | CNT_W | Write hold length |
| mem_ready | input | 1 | Asynchronous ready from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_be_n | output | DATA_W/8 | Byte enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | DATA_W | Data bus out value |
| mem_dq_oe | output | 1 | Data bus driver enable, 0 = tri-state |
| mem_dq_i | input | DATA_W | Data bus in value |

## Verification
Reads and writes are run with unequal, asymmetric lengths while the unused set holds different values, so a swap of the two configuration sets shows up as a wrong phase count. Zero lengths and a one-cycle strobe test the minimum-length case. Ready is dropped and then released at chosen strobe cycles. A release that lands before the window must leave the strobe at its nominal length, and a release inside or past the window must give exactly m+4 cycles; together these separate a wrong window start from a wrong release latency. The read data model returns a marker value whenever output enable is high, so a capture one edge late is caught. A request raised while the block is busy, and configuration changed in the middle of a cycle, show whether the block captures its inputs only at acceptance.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;
endpackage

// File: rtl/amseq_sync.sv
module amseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("amseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/amseq_fsm.sv
module amseq_fsm
   import amseq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_setup,
   input  logic [CNT_W-1:0] len_strobe,
   input  logic [CNT_W-1:0] len_hold,
   input  logic             rdy_s,
   output phase_e           phase,
   output logic             strobe_last,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("amseq_fsm: CNT_W must be at least 2");
   end

   function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] v);
      return (v == '0) ? ONE : v;
   endfunction

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] strobe_q;
   logic [CNT_W-1:0] hold_q;
   logic             waiting;
   logic             released;
   logic             in_win;

   always_comb begin
      in_win      = (cnt <= ONE);
      strobe_last = (phase == PH_STROBE) && (cnt == '0) &&
                    (released || (!waiting && rdy_s));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         strobe_q <= ONE;
         hold_q   <= ONE;
         waiting  <= 1'b0;
         released <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase    <= PH_SETUP;
                  cnt      <= eff(len_setup) - ONE;
                  strobe_q <= eff(len_strobe);
                  hold_q   <= eff(len_hold);
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  phase    <= PH_STROBE;
                  cnt      <= strobe_q - ONE;
                  waiting  <= 1'b0;
                  released <= 1'b0;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_STROBE: begin
               if (strobe_last) begin
                  phase    <= PH_HOLD;
                  cnt      <= hold_q - ONE;
                  waiting  <= 1'b0;
                  released <= 1'b0;
               end else if (waiting && !released) begin
                  if (rdy_s) begin
                     released <= 1'b1;
                     cnt      <= '0;
                  end
               end else if (in_win && !rdy_s) begin
                  waiting <= 1'b1;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_HOLD: begin
               if (cnt == '0) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R2
   start_to_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (phase == PH_SETUP));

   // R7
   wait_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> (phase == PH_STROBE));

   // R8
   release_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && released) |=> (phase == PH_HOLD));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase == PH_IDLE));
endmodule

// File: rtl/amseq_dpath.sv
module amseq_dpath
   import amseq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   input  phase_e            phase,
   input  logic              strobe_last,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_cs_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BE_W-1:0]   mem_be_n,
   output logic              mem_oe_n,
   output logic              mem_re_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   output logic [DATA_W-1:0] rd_data
);
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wdata_q;
   logic              sel;
   logic              strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (capture) begin
         wr_q    <= req_write;
         addr_q  <= req_addr;
         be_q    <= req_be;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rd_data <= '0;
      else if (strobe_last && !wr_q) rd_data <= mem_dq_i;
   end

   always_comb begin
      sel       = (phase != PH_IDLE);
      strb      = (phase == PH_STROBE);
      mem_cs_n  = !sel;
      mem_addr  = addr_q;
      mem_be_n  = sel ? ~be_q : '1;
      mem_oe_n  = !(strb && !wr_q);
      mem_re_n  = !(strb && !wr_q);
      mem_we_n  = !(strb && wr_q);
      mem_dq_o  = wdata_q;
      mem_dq_oe = sel && wr_q;
   end

   // R5
   strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_re_n));

   // R6
   we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

   // R5
   oe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   // R11
   sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
   import amseq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int BE_W       = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   input  logic [CNT_W-1:0]  cfg_rd_setup,
   input  logic [CNT_W-1:0]  cfg_rd_strobe,
   input  logic [CNT_W-1:0]  cfg_rd_hold,
   input  logic [CNT_W-1:0]  cfg_wr_setup,
   input  logic [CNT_W-1:0]  cfg_wr_strobe,
   input  logic [CNT_W-1:0]  cfg_wr_hold,
   input  logic              mem_ready,
   output logic              mem_cs_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BE_W-1:0]   mem_be_n,
   output logic              mem_oe_n,
   output logic              mem_re_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
      $error("async_mem_seq: DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("async_mem_seq: ADDR_W must be at least 1");
   end

   phase_e           phase;
   logic             start;
   logic             rdy_s;
   logic             strobe_last;
   logic [CNT_W-1:0] sel_setup;
   logic [CNT_W-1:0] sel_strobe;
   logic [CNT_W-1:0] sel_hold;

   always_comb begin
      req_ready  = (phase == PH_IDLE);
      start      = req_valid && req_ready;
      sel_setup  = req_write ? cfg_wr_setup  : cfg_rd_setup;
      sel_strobe = req_write ? cfg_wr_strobe : cfg_rd_strobe;
      sel_hold   = req_write ? cfg_wr_hold   : cfg_rd_hold;
   end

   amseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (mem_ready),
      .q_sync  (rdy_s)
   );

   amseq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .len_setup   (sel_setup),
      .len_strobe  (sel_strobe),
      .len_hold    (sel_hold),
      .rdy_s       (rdy_s),
      .phase       (phase),
      .strobe_last (strobe_last),
      .done        (done)
   );

   amseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dpath (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (start),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_be      (req_be),
      .req_wdata   (req_wdata),
      .phase       (phase),
      .strobe_last (strobe_last),
      .mem_dq_i    (mem_dq_i),
      .mem_cs_n    (mem_cs_n),
      .mem_addr    (mem_addr),
      .mem_be_n    (mem_be_n),
      .mem_oe_n    (mem_oe_n),
      .mem_re_n    (mem_re_n),
      .mem_we_n    (mem_we_n),
      .mem_dq_o    (mem_dq_o),
      .mem_dq_oe   (mem_dq_oe),
      .rd_data     (rd_data)
   );

   // R10
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mem_cs_n && req_ready));
endmodule

// File: tb/sim_async_mem_seq.sv
`timescale 1ns/1ps
module sim_async_mem_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rd_data;
   logic        done;
   logic [3:0]  cfg_rd_setup = 4'd1, cfg_rd_strobe = 4'd1, cfg_rd_hold = 4'd1;
   logic [3:0]  cfg_wr_setup = 4'd1, cfg_wr_strobe = 4'd1, cfg_wr_hold = 4'd1;
   logic        mem_ready = 1'b1;
   logic        mem_cs_n, mem_oe_n, mem_re_n, mem_we_n, mem_dq_oe;
   logic [19:0] mem_addr;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_o;
   logic [15:0] mem_dq_i;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   function automatic logic [15:0] model(input logic [19:0] a);
      return a[15:0] ^ 16'h5A5A;
   endfunction

   assign mem_dq_i = (!mem_oe_n) ? model(mem_addr) : 16'hBAD0;

   async_mem_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
      .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe),
      .cfg_rd_hold(cfg_rd_hold), .cfg_wr_setup(cfg_wr_setup),
      .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
      .mem_ready(mem_ready), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
      .mem_be_n(mem_be_n), .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n),
      .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int exp_strobe(input int t, input int m);
      int te = eff(t);
      int w  = (te >= 2) ? te - 2 : 0;
      if (m < 0)      return te;
      if (m + 2 <= w) return te;
      return m + 4;
   endfunction

   task automatic run_op(input string nm, input bit wr, input logic [19:0] a,
                         input logic [1:0] be, input logic [15:0] wd,
                         input int s, input int t, input int h, input int rel_m,
                         input bit busy_poke, input bit cfg_poke);
      int n_set = 0, n_str = 0, n_hold = 0, bad_pin = 0, bad_rdy = 0;
      bit got_done = 0, done_cs_ok = 0;
      @(negedge clk);
      mem_ready = (rel_m < 0);
      if (wr) begin
         cfg_wr_setup = 4'(s); cfg_wr_strobe = 4'(t); cfg_wr_hold = 4'(h);
         cfg_rd_setup = 4'(h + 3); cfg_rd_strobe = 4'(s + 2); cfg_rd_hold = 4'(t + 1);
      end else begin
         cfg_rd_setup = 4'(s); cfg_rd_strobe = 4'(t); cfg_rd_hold = 4'(h);
         cfg_wr_setup = 4'(h + 3); cfg_wr_strobe = 4'(s + 2); cfg_wr_hold = 4'(t + 1);
      end
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
      for (int i = 0; i < 300 && !got_done; i++) begin
         @(negedge clk);
         if (done) begin
            got_done = 1;
            done_cs_ok = mem_cs_n && req_ready;
         end else begin
            logic strobe_n;
            strobe_n = wr ? mem_we_n : mem_re_n;
            if (req_ready) bad_rdy++;
            if (mem_cs_n) bad_pin++;
            if (mem_addr != a || mem_be_n != ~be) bad_pin++;
            if (wr) begin
               if (!mem_dq_oe || mem_dq_o != wd || !mem_oe_n || !mem_re_n) bad_pin++;
            end else begin
               if (mem_dq_oe || !mem_we_n || (mem_oe_n != mem_re_n)) bad_pin++;
            end
            if (!strobe_n) begin
               if (n_str == rel_m) mem_ready = 1'b1;
               n_str++;
            end else if (n_str == 0) n_set++;
            else n_hold++;
         end
         if (i == 0) begin
            req_valid = busy_poke;
            req_addr  = busy_poke ? ~a : a;
            req_write = busy_poke ? !wr : wr;
            if (cfg_poke) begin
               cfg_rd_setup = 4'd15; cfg_rd_strobe = 4'd15; cfg_rd_hold = 4'd15;
               cfg_wr_setup = 4'd15; cfg_wr_strobe = 4'd15; cfg_wr_hold = 4'd15;
               req_be = ~be; req_wdata = ~wd;
            end
         end
         if (i == 1) req_valid = 1'b0;
      end
      chk(got_done, {nm, " R9 done seen"}, int'(got_done), 1);
      chk(done_cs_ok, {nm, " R9 selects released at done"}, int'(done_cs_ok), 1);
      chk(n_set == eff(s), {nm, " R2 setup length"}, n_set, eff(s));
      chk(n_str == exp_strobe(t, rel_m), {nm, " R3 R8 strobe length"}, n_str, exp_strobe(t, rel_m));
      chk(n_hold == eff(h), {nm, " R3 hold length"}, n_hold, eff(h));
      chk(bad_pin == 0, {nm, wr ? " R6 R12 write pins" : " R5 R12 read pins"}, bad_pin, 0);
      chk(bad_rdy == 0, {nm, " R10 req_ready low while busy"}, bad_rdy, 0);
      if (!wr) chk(rd_data == model(a), {nm, " R5 read capture"}, rd_data, model(a));
      if (busy_poke || cfg_poke) begin
         int extra = 0;
         repeat (3) begin
            @(negedge clk);
            if (!mem_cs_n || done) extra++;
         end
         chk(extra == 0, {nm, " R10 R11 no extra cycle"}, extra, 0);
      end
      mem_ready = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(mem_cs_n && mem_oe_n && mem_re_n && mem_we_n, "R1 strobes idle",
          int'({mem_cs_n, mem_oe_n, mem_re_n, mem_we_n}), 15);
      chk(mem_be_n == 2'b11 && !mem_dq_oe, "R1 be_n and bus idle",
          int'({mem_be_n, mem_dq_oe}), 6);
      chk(!done && req_ready, "R1 done low ready high", int'({done, req_ready}), 1);
   endtask

   task automatic t_read_basic;   run_op("rd_basic", 0, 20'h01234, 2'b11, 16'h0, 2, 3, 1, -1, 0, 0); endtask
   task automatic t_write_basic;  run_op("wr_basic", 1, 20'h0ABCD, 2'b10, 16'hC3A5, 1, 4, 2, -1, 0, 0); endtask
   task automatic t_zero_len;
      run_op("rd_zero R4", 0, 20'h00F0F, 2'b01, 16'h0, 0, 0, 0, -1, 0, 0);
      run_op("wr_zero R4", 1, 20'h00777, 2'b11, 16'h1111, 0, 0, 0, -1, 0, 0);
   endtask
   task automatic t_ready_early;  run_op("rdy_early R7", 0, 20'h00321, 2'b11, 16'h0, 1, 5, 1, 0, 0, 0); endtask
   task automatic t_ready_stretch;
      run_op("rdy_wr R8", 1, 20'h04444, 2'b01, 16'h8E8E, 2, 3, 1, 3, 0, 0);
      run_op("rdy_rd1 R8", 0, 20'h05555, 2'b11, 16'h0, 1, 1, 2, 2, 0, 0);
      run_op("rdy_rd2 R7 R8", 0, 20'h06006, 2'b10, 16'h0, 1, 2, 1, 0, 0, 0);
   endtask
   task automatic t_busy_req;     run_op("busy R10", 1, 20'h09999, 2'b10, 16'h0F0F, 3, 2, 3, -1, 1, 0); endtask
   task automatic t_cfg_change;
      run_op("cfgchg R11", 0, 20'h0AAAA, 2'b01, 16'h0, 1, 2, 1, -1, 0, 1);
      run_op("cfgchg_wr R11", 1, 20'h0BBBB, 2'b11, 16'h1234, 2, 1, 2, -1, 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_basic();
      t_write_basic();
      t_zero_len();
      t_ready_early();
      t_ready_stretch();
      t_busy_req();
      t_cfg_change();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule